// File: doc/BRIEF.md
# Tone Steering and Output Latch

This block stands in for the resistor-capacitor guard-time network that normally sits beside a dual-tone receiver. It watches the early-steering flag and the 4-bit key code that a tone detector produces. The flag must stay high for a programmable tone-present guard time before the code is captured in an output latch. A delayed-steering flag then rises after a fixed settling delay. A second, independent tone-absent guard time confirms the pause between digits, so short dropouts in the middle of a tone do not end it.

Guard times are counted in ticks of an internal prescaler. With the default divide ratio, one tick is about 1 ms of a 3.579545 MHz clock. Each guard time is an 8-bit tick count. The data bus is modelled as a valid/enable pair that is controlled by an output-enable input. A power-down input freezes all timing and keeps the latch contents.

Top module: `tone_steer`

## Requirements
- R1: A code is registered only when `est_in` is sampled high on `gtp_ticks*CLK_PER_TICK+1` consecutive rising clock edges. The value registered is `code_in` at the last of those edges.
- R2: A burst of `est_in` that is sampled high on `gtp_ticks*CLK_PER_TICK` edges or fewer leaves the latch unchanged, and `std_out` stays low.
- R3: `gtp_ticks` and `gta_ticks` act independently. A value of 0 in either one behaves as 1 tick. One tick lasts `CLK_PER_TICK` cycles, and each qualify window starts counting afresh whenever `est_in` changes.
- R4: `std_out` rises exactly `SETTLE_CYC` cycles after the latch is updated, and the latch does not change in between. Counted from the first edge that sees `est_in` high, `std_out` is high after edge `gtp_ticks*CLK_PER_TICK+SETTLE_CYC+1`.
- R5: After a registration, `std_out` falls once `est_in` has been sampled low on `gta_ticks*CLK_PER_TICK` consecutive edges. It is low after the edge at that count plus one, counted from the first low edge.
- R6: A dropout of `est_in` shorter than the tone-absent guard time keeps `std_out` high. The latch is not reloaded, even if `code_in` changes.
- R7: After a valid pause, the latch keeps the last registered code until the next registration.
- R8: With `oe` low, `q_valid` is 0 and `q_data` is all zeros (this stands in for high impedance). With `oe` high, `q_valid` is 1 and `q_data` shows the latch, including a code that was registered while `oe` was low.
- R9: While `pwr_dn` is high, `std_out` is low one cycle later, nothing is registered, and the latch holds its value. After `pwr_dn` falls, the block starts in the idle state, so a flag that is already high must qualify for the full guard time again.
- R10: Reset (`rst` high at a clock edge) clears the latch to 0, drives `std_out` low and returns the state machine to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down: stops timing and registration |
| est_in | input | 1 | Early-steering flag from the tone detector |
| code_in | input | CODE_W | Key code from the tone detector |
| gtp_ticks | input | GUARD_W | Tone-present guard time, in ticks |
| gta_ticks | input | GUARD_W | Tone-absent guard time, in ticks |
| oe | input | 1 | Output enable for the data bus |
| q_data | output | CODE_W | Latched code, all zeros while disabled |
| q_valid | output | 1 | High when `q_data` is driven |
| std_out | output | 1 | Delayed-steering flag |

## Verification
The bench builds the block with `CLK_PER_TICK=4` and `SETTLE_CYC=3`. A tick is then four cycles, so the bench can measure qualify windows of a few ticks to the exact cycle and can place bursts one edge either side of the accept boundary. A short settle value keeps the gap from latch update to the delayed flag visible, while the power-down and dropout sequences stay within a few dozen cycles. The bench also changes the guard inputs at run time, covering asymmetric windows and the zero-tick case.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

    localparam int DEF_CODE_W  = 4;
    localparam int DEF_GUARD_W = 8;

    // Qualification states of the steering machine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QPRES = 2'd1,
        ST_REG   = 2'd2,
        ST_QABS  = 2'd3
    } steer_st_e;

    // Control pulses from the state machine to the prescaler and latch
    typedef struct packed {
        logic restart;   // clear the tick prescaler
        logic load;      // capture code into the output latch
        logic release_t; // confirmed pause: drop delayed steering
    } steer_ctl_t;

    // Width of a counter that must hold values 0..n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tsl_tick_gen.sv
module tsl_tick_gen #(
    parameter int DIV = 3580
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    import tone_steer_pkg::*;

    localparam int PW = cnt_width(DIV - 1);

    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            logic [PW-1:0] pcnt;
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    pcnt <= '0;
                end else if (pcnt == PW'(DIV - 1)) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
            assign tick = (pcnt == PW'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/tsl_guard_fsm.sv
module tsl_guard_fsm #(
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pd,
    input  logic               est,
    input  logic               tick,
    input  logic [GUARD_W-1:0] gtp,
    input  logic [GUARD_W-1:0] gta,
    output tone_steer_pkg::steer_ctl_t ctl
);
    import tone_steer_pkg::*;

    steer_st_e           st, st_n;
    logic [GUARD_W-1:0]  cnt, cnt_n;
    logic [GUARD_W:0]    cnt_inc;
    logic [GUARD_W:0]    gtp_eff, gta_eff;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign gtp_eff = (gtp == '0) ? (GUARD_W+1)'(1) : {1'b0, gtp};
    assign gta_eff = (gta == '0) ? (GUARD_W+1)'(1) : {1'b0, gta};

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        ctl   = '0;
        if (pd) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (est) begin
                        st_n        = ST_QPRES;
                        cnt_n       = '0;
                        ctl.restart = 1'b1;
                    end
                end
                ST_QPRES: begin
                    if (!est) begin
                        st_n        = ST_IDLE;
                        cnt_n       = '0;
                        ctl.restart = 1'b1;
                    end else if (tick) begin
                        if (cnt_inc >= gtp_eff) begin
                            st_n     = ST_REG;
                            cnt_n    = '0;
                            ctl.load = 1'b1;
                        end else begin
                            cnt_n = cnt_inc[GUARD_W-1:0];
                        end
                    end
                end
                ST_REG: begin
                    if (!est) begin
                        st_n        = ST_QABS;
                        cnt_n       = '0;
                        ctl.restart = 1'b1;
                    end
                end
                ST_QABS: begin
                    if (est) begin
                        st_n        = ST_REG;
                        cnt_n       = '0;
                        ctl.restart = 1'b1;
                    end else if (tick) begin
                        if (cnt_inc >= gta_eff) begin
                            st_n          = ST_IDLE;
                            cnt_n         = '0;
                            ctl.release_t = 1'b1;
                        end else begin
                            cnt_n = cnt_inc[GUARD_W-1:0];
                        end
                    end
                end
                default: begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

endmodule

// File: rtl/tsl_out_latch.sv
module tsl_out_latch #(
    parameter int CODE_W = 4,
    parameter int SETTLE = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd,
    input  logic              load,
    input  logic              release_t,
    input  logic [CODE_W-1:0] code_in,
    input  logic              oe,
    output logic [CODE_W-1:0] latch_q,
    output logic              std_q,
    output logic [CODE_W-1:0] q_data,
    output logic              q_valid
);
    import tone_steer_pkg::*;

    localparam int SETTLE_EFF = (SETTLE < 1) ? 1 : SETTLE;
    localparam int SW         = cnt_width(SETTLE_EFF);

    logic [SW-1:0] scnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            scnt    <= '0;
            std_q   <= 1'b0;
        end else begin
            if (load) begin
                latch_q <= code_in;
            end
            if (pd || release_t) begin
                scnt  <= '0;
                std_q <= 1'b0;
            end else if (load) begin
                scnt <= SW'(SETTLE_EFF);
            end else if (scnt != '0) begin
                scnt <= scnt - 1'b1;
                if (scnt == SW'(1)) begin
                    std_q <= 1'b1;
                end
            end
        end
    end

    assign q_valid = oe;
    assign q_data  = oe ? latch_q : '0;

endmodule

// File: rtl/tone_steer.sv
module tone_steer #(
    parameter int CLK_PER_TICK = 3580,
    parameter int SETTLE_CYC   = 18,
    parameter int CODE_W       = tone_steer_pkg::DEF_CODE_W,
    parameter int GUARD_W      = tone_steer_pkg::DEF_GUARD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_dn,
    input  logic               est_in,
    input  logic [CODE_W-1:0]  code_in,
    input  logic [GUARD_W-1:0] gtp_ticks,
    input  logic [GUARD_W-1:0] gta_ticks,
    input  logic               oe,
    output logic [CODE_W-1:0]  q_data,
    output logic               q_valid,
    output logic               std_out
);
    import tone_steer_pkg::*;

    steer_ctl_t        ctl;
    logic              tick;
    logic [CODE_W-1:0] latch_q;

    tsl_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (pwr_dn | ctl.restart),
        .tick (tick)
    );

    tsl_guard_fsm #(.GUARD_W(GUARD_W)) u_fsm (
        .clk  (clk),
        .rst  (rst),
        .pd   (pwr_dn),
        .est  (est_in),
        .tick (tick),
        .gtp  (gtp_ticks),
        .gta  (gta_ticks),
        .ctl  (ctl)
    );

    tsl_out_latch #(.CODE_W(CODE_W), .SETTLE(SETTLE_CYC)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .pd        (pwr_dn),
        .load      (ctl.load),
        .release_t (ctl.release_t),
        .code_in   (code_in),
        .oe        (oe),
        .latch_q   (latch_q),
        .std_q     (std_out),
        .q_data    (q_data),
        .q_valid   (q_valid)
    );

endmodule

// File: rtl/tone_steer_chk.sv
module tone_steer_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_dn,
    input logic              est_in,
    input logic              std_out,
    input logic [CODE_W-1:0] latch_q
);

    // R4
    settle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(std_out) |-> $stable(latch_q));

    // R9
    pd_std_low_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !std_out);

    // R9
    pd_latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_dn) |-> $stable(latch_q));

    // R6
    no_reload_while_std_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(latch_q) |-> !$past(std_out));

    // R1
    load_needs_est_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(latch_q) |-> $past(est_in));

    // R5
    std_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(std_out) |-> (!$past(est_in) || $past(pwr_dn)));

endmodule

bind tone_steer tone_steer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pwr_dn  (pwr_dn),
    .est_in  (est_in),
    .std_out (std_out),
    .latch_q (latch_q)
);

// File: tb/sim_tone_steer.sv
`timescale 1ns/1ps
module sim_tone_steer;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int SETTLE     = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_dn = 1'b0;
    logic       est_in = 1'b0;
    logic [3:0] code_in = '0;
    logic [7:0] gtp_ticks = 8'd5;
    logic [7:0] gta_ticks = 8'd3;
    logic       oe = 1'b0;
    logic [3:0] q_data;
    logic       q_valid;
    logic       std_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    int         rises = 0;
    int         pushes = 0;
    logic [3:0] deferred = '0;
    logic       std_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tone_steer #(.CLK_PER_TICK(DIV), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .est_in(est_in),
        .code_in(code_in), .gtp_ticks(gtp_ticks), .gta_ticks(gta_ticks),
        .oe(oe), .q_data(q_data), .q_valid(q_valid), .std_out(std_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c);
        exp_q.push_back(c);
        pushes++;
    endtask

    task automatic wait_std(input logic want, output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while (std_out !== want && n < 300);
    endtask

    // Drive one tone; expect registration when held more than gtp*DIV edges
    task automatic tone(input logic [3:0] c, input int hi, input int lo);
        int g;
        g = (gtp_ticks == 0) ? 1 : int'(gtp_ticks);
        if (hi > g * DIV) push(c);
        code_in = c;
        est_in  = 1'b1;
        repeat (hi) @(negedge clk);
        est_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    // Scoreboard monitor: compare each delayed-steering rise with the queue
    always @(negedge clk) begin
        if (!rst && std_out && !std_prev) begin
            rises++;
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 actual=registration expected=none (code %0d)", q_data);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                if (q_valid) begin
                    check("R1 registered code", q_data, e);
                end else begin
                    check("R8 disabled bus zero", q_data, 0);
                    deferred = e;
                end
            end
        end
        std_prev = std_out;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 std after reset", std_out, 0);
        check("R8 valid low when disabled", q_valid, 0);
        check("R8 data zero when disabled", q_data, 0);
        oe = 1'b1;
        @(negedge clk);
        check("R10 latch cleared", q_data, 0);
        check("R8 valid high when enabled", q_valid, 1);

        // R1 R4 exact registration timing, R5 exact release timing
        code_in = 4'd5;
        est_in  = 1'b1;
        push(4'd5);
        wait_std(1'b1, n);
        check("R4 rise cycle", n, 5*DIV + SETTLE + 1);
        repeat (5) @(negedge clk);
        est_in = 1'b0;
        wait_std(1'b0, n);
        check("R5 fall cycle", n, 3*DIV + 1);
        repeat (20) @(negedge clk);

        // R2 burst exactly at the reject boundary
        tone(4'd9, 5*DIV, 30);
        check("R2 latch unchanged after short burst", q_data, 5);
        check("R7 last code held", q_data, 5);
        // R1 one edge longer is accepted
        tone(4'd9, 5*DIV + 1, 30);
        check("R1 boundary accept", q_data, 9);

        // R6 dropout tolerated
        push(4'd3);
        code_in = 4'd3;
        est_in  = 1'b1;
        repeat (40) @(negedge clk);
        est_in  = 1'b0;
        code_in = 4'd12;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R6 std held during dropout", std_out, 1);
        end
        est_in = 1'b1;
        repeat (20) @(negedge clk);
        check("R6 std after dropout", std_out, 1);
        check("R6 latch not reloaded", q_data, 3);
        est_in = 1'b0;
        repeat (30) @(negedge clk);
        check("R6 single rise", rises, pushes);

        // R7 code held across a long pause
        repeat (50) @(negedge clk);
        check("R7 code after pause", q_data, 3);

        // R8 registration while disabled
        oe = 1'b0;
        tone(4'd14, 40, 30);
        check("R8 data zero while disabled", q_data, 0);
        oe = 1'b1;
        @(negedge clk);
        check("R8 deferred code visible", q_data, deferred);
        check("R8 code registered while disabled", q_data, 14);

        // R3 independent guard times
        gtp_ticks = 8'd2;
        gta_ticks = 8'd6;
        code_in   = 4'd7;
        est_in    = 1'b1;
        push(4'd7);
        wait_std(1'b1, n);
        check("R3 short present window", n, 2*DIV + SETTLE + 1);
        est_in = 1'b0;
        wait_std(1'b0, n);
        check("R3 long absent window", n, 6*DIV + 1);
        repeat (10) @(negedge clk);
        gtp_ticks = 8'd0;
        code_in   = 4'd10;
        est_in    = 1'b1;
        push(4'd10);
        wait_std(1'b1, n);
        check("R3 zero guard acts as one tick", n, DIV + SETTLE + 1);
        est_in = 1'b0;
        repeat (40) @(negedge clk);
        gtp_ticks = 8'd5;
        gta_ticks = 8'd3;
        @(negedge clk);

        // R9 power-down
        pwr_dn  = 1'b1;
        code_in = 4'd6;
        est_in  = 1'b1;
        repeat (40) @(negedge clk);
        check("R9 no std in power-down", std_out, 0);
        check("R9 latch kept in power-down", q_data, 10);
        pwr_dn = 1'b0;
        push(4'd6);
        wait_std(1'b1, n);
        check("R9 full requalify after power-down", n, 5*DIV + SETTLE + 1);
        repeat (3) @(negedge clk);
        pwr_dn = 1'b1;
        @(negedge clk);
        check("R9 std dropped by power-down", std_out, 0);
        check("R9 latch kept after power-down", q_data, 6);
        est_in = 1'b0;
        repeat (5) @(negedge clk);
        pwr_dn = 1'b0;
        repeat (30) @(negedge clk);

        check("R1 scoreboard drained", exp_q.size(), 0);
        check("R1 rise count", rises, pushes);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule